// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds eight 80-bit registers that are used as a stack. They are always addressed relative to a 3-bit top-of-stack pointer: ST(i) is the register at physical index (top + i) mod 8. Each physical register carries an empty tag. The block treats every value as an opaque 80-bit word. Arithmetic, format conversion and memory access happen elsewhere.

One request arrives per clock, as an opcode and a relative index. The requests are push a value, push a copy of ST(i), store ST(0) into ST(i) with or without a pop, exchange ST(0) with ST(i) or with ST(1), and pop. ST(0) is always visible on a read port. ST(i) is visible on a second read port, selected by the index input at any time.

The status word carries the pointer, a stack-fault flag, an invalid-operation flag and the C1 bit. C1 tells an overflow from an underflow when a stack fault occurs. A request that faults leaves the pointer, the tags and the register contents as they were.

Top module: `fp_stack_ctrl`

## Requirements
- R1: After reset the pointer is 0, all eight registers are empty, and the status word reads 0.
- R2: Opcode 1 (push value) decrements the pointer modulo 8. It then writes the value into the register the new pointer selects and marks that register valid, so ST(0) equals the pushed value.
- R3: Opcode 2 (push copy) resolves ST(i) with the pointer value before the decrement. With i=0 it duplicates the top.
- R4: Opcode 3 (store) copies ST(0) into ST(i) and marks ST(i) valid. The pointer does not change.
- R5: Opcode 4 (store and pop) writes ST(i) using the index before the pop, then empties the old top and increments the pointer. With i=0 it only discards the top. With i=1 the old ST(0) remains on top.
- R6: Opcode 5 exchanges ST(0) with ST(i), and opcode 6 exchanges ST(0) with ST(1) whatever the index is. Both always return C1=0.
- R7: Opcode 7 (pop) marks the top register empty and increments the pointer modulo 8.
- R8: A push of either kind onto an occupied destination register (a full stack) sets stack fault with C1=1.
- R9: A store, exchange or pop whose ST(0) is empty sets stack fault with C1=0. Stores and exchanges in this case also set invalid operation.
- R10: A push copy from an empty ST(i), or an exchange with an empty ST(i) while ST(0) is valid, sets invalid operation without stack fault.
- R11: A request that sets stack fault or invalid operation leaves the pointer, the tags and all register contents unchanged.
- R12: The status word holds the pointer in bits 13:11, C1 in bit 9, stack fault in bit 6 and invalid operation in bit 0, with all other bits 0. Every accepted request with an opcode from 1 to 7 rewrites the flags; a successful request leaves all three flags 0. Opcode 0, or an idle cycle, leaves the status unchanged.
- R13: ST(i) is read from physical register (top + i) mod 8, and the pointer wraps modulo 8 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Request opcode |
| idx_i | input | 3 | Relative register index i; also selects the sti_o read port |
| push_data_i | input | 80 | Value for a push-value request |
| st0_o | output | 80 | Contents of ST(0) |
| sti_o | output | 80 | Contents of ST(idx_i) |
| status_o | output | 16 | Status word holding the pointer, C1, stack fault and invalid operation |
| stack_fault_o | output | 1 | Stack fault from the last accepted request |
| invalid_o | output | 1 | Invalid operation from the last accepted request |
| c1_o | output | 1 | C1 from the last accepted request |

## Verification
The assertions take for granted that the opcode, the index and the strobe are known, two-state values on every clock edge after reset. They also assume that the index seen by the ST(i) read port during a request cycle is the index of that request. The stimulus changes the inputs only on falling edges and keeps the opcode inside its eight defined codes. It moves the index away from the request only while the strobe is low. The random part mixes pushes and pops so that the stack reaches both its full and its empty state many times. The directed part covers the index-0 and index-1 cases of duplicate and store-and-pop.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    FPS_NOP       = 3'd0,
    FPS_PUSH      = 3'd1,
    FPS_DUP       = 3'd2,
    FPS_STORE     = 3'd3,
    FPS_STORE_POP = 3'd4,
    FPS_XCHG      = 3'd5,
    FPS_XCHG1     = 3'd6,
    FPS_POP       = 3'd7
  } fps_op_e;

  typedef struct packed {
    logic sf;
    logic c1;
    logic ie;
  } fps_flags_t;

  localparam int unsigned STAT_W       = 16;
  localparam int unsigned STAT_TOP_LSB = 11;
  localparam int unsigned STAT_C1      = 9;
  localparam int unsigned STAT_SF      = 6;
  localparam int unsigned STAT_IE      = 0;
endpackage

// File: rtl/fps_index.sv
module fps_index #(
  parameter int unsigned PTR_W = 3
) (
  input  logic [PTR_W-1:0] base_i,
  input  logic [PTR_W-1:0] off_i,
  output logic [PTR_W-1:0] phys_o
);
  // modulo 2^PTR_W by truncation
  assign phys_o = base_i + off_i;
endmodule

// File: rtl/fps_regfile.sv
module fps_regfile #(
  parameter int unsigned DATA_W = 80,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned NRD    = 4,
  localparam int unsigned DEPTH = 1 << PTR_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wa_en_i,
  input  logic [PTR_W-1:0]             wa_addr_i,
  input  logic [DATA_W-1:0]            wa_data_i,
  input  logic                         wb_en_i,
  input  logic [PTR_W-1:0]             wb_addr_i,
  input  logic [DATA_W-1:0]            wb_data_i,
  input  logic [DEPTH-1:0]             tag_clr_i,
  input  logic [DEPTH-1:0]             tag_set_i,
  input  logic [NRD-1:0][PTR_W-1:0]    rd_addr_i,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data_o,
  output logic [NRD-1:0]               rd_empty_o
);
  logic [DEPTH-1:0][DATA_W-1:0] regs_q;
  logic [DEPTH-1:0]             empty_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[k] <= '0;
      end else if (wb_en_i && wb_addr_i == PTR_W'(k)) begin
        regs_q[k] <= wb_data_i;
      end else if (wa_en_i && wa_addr_i == PTR_W'(k)) begin
        regs_q[k] <= wa_data_i;
      end
    end

    // set wins: store-and-pop to ST(0) writes and empties one slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           empty_q[k] <= 1'b1;
      else if (tag_set_i[k]) empty_q[k] <= 1'b1;
      else if (tag_clr_i[k]) empty_q[k] <= 1'b0;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r]  = regs_q[rd_addr_i[r]];
    assign rd_empty_o[r] = empty_q[rd_addr_i[r]];
  end
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned DATA_W = 80,
  parameter int unsigned PTR_W  = 3,
  localparam int unsigned DEPTH = 1 << PTR_W
) (
  input  logic               valid_i,
  input  fps_op_e            op_i,
  input  logic [PTR_W-1:0]   top_i,
  input  logic [PTR_W-1:0]   opnd_addr_i,
  input  logic [PTR_W-1:0]   dst_addr_i,
  input  logic               st0_empty_i,
  input  logic               opnd_empty_i,
  input  logic               dst_empty_i,
  input  logic [DATA_W-1:0]  st0_i,
  input  logic [DATA_W-1:0]  opnd_i,
  input  logic [DATA_W-1:0]  push_data_i,
  output logic               wa_en_o,
  output logic [PTR_W-1:0]   wa_addr_o,
  output logic [DATA_W-1:0]  wa_data_o,
  output logic               wb_en_o,
  output logic [PTR_W-1:0]   wb_addr_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic [DEPTH-1:0]   tag_clr_o,
  output logic [DEPTH-1:0]   tag_set_o,
  output logic [PTR_W-1:0]   top_nxt_o,
  output logic               flag_en_o,
  output fps_flags_t         flags_o
);
  always_comb begin
    wa_en_o   = 1'b0;
    wa_addr_o = dst_addr_i;
    wa_data_o = push_data_i;
    wb_en_o   = 1'b0;
    wb_addr_o = opnd_addr_i;
    wb_data_o = st0_i;
    tag_clr_o = '0;
    tag_set_o = '0;
    top_nxt_o = top_i;
    flag_en_o = 1'b0;
    flags_o   = '0;
    if (valid_i) begin
      unique case (op_i)
        FPS_PUSH, FPS_DUP: begin
          flag_en_o = 1'b1;
          if (!dst_empty_i) begin
            flags_o.sf = 1'b1;
            flags_o.c1 = 1'b1;
          end else if (op_i == FPS_DUP && opnd_empty_i) begin
            flags_o.ie = 1'b1;
          end else begin
            wa_en_o               = 1'b1;
            wa_addr_o             = dst_addr_i;
            wa_data_o             = (op_i == FPS_DUP) ? opnd_i : push_data_i;
            tag_clr_o[dst_addr_i] = 1'b1;
            top_nxt_o             = dst_addr_i;
          end
        end
        FPS_STORE, FPS_STORE_POP: begin
          flag_en_o = 1'b1;
          if (st0_empty_i) begin
            flags_o.sf = 1'b1;
            flags_o.ie = 1'b1;
          end else begin
            wa_en_o                = 1'b1;
            wa_addr_o              = opnd_addr_i;
            wa_data_o              = st0_i;
            tag_clr_o[opnd_addr_i] = 1'b1;
            if (op_i == FPS_STORE_POP) begin
              tag_set_o[top_i] = 1'b1;
              top_nxt_o        = top_i + 1'b1;
            end
          end
        end
        FPS_XCHG, FPS_XCHG1: begin
          flag_en_o = 1'b1;
          if (st0_empty_i) begin
            flags_o.sf = 1'b1;
            flags_o.ie = 1'b1;
          end else if (opnd_empty_i) begin
            flags_o.ie = 1'b1;
          end else begin
            wa_en_o   = 1'b1;
            wa_addr_o = top_i;
            wa_data_o = opnd_i;
            wb_en_o   = 1'b1;
            wb_addr_o = opnd_addr_i;
            wb_data_o = st0_i;
          end
        end
        FPS_POP: begin
          flag_en_o = 1'b1;
          if (st0_empty_i) begin
            flags_o.sf = 1'b1;
          end else begin
            tag_set_o[top_i] = 1'b1;
            top_nxt_o        = top_i + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned DATA_W = 80,
  parameter int unsigned PTR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [PTR_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] st0_o,
  output logic [DATA_W-1:0] sti_o,
  output logic [15:0]       status_o,
  output logic              stack_fault_o,
  output logic              invalid_o,
  output logic              c1_o
);
  localparam int unsigned DEPTH = 1 << PTR_W;
  localparam int unsigned NRD   = 4;
  localparam int unsigned RD_ST0 = 0, RD_OPND = 1, RD_DST = 2, RD_EXT = 3;

  fps_op_e    op;
  logic [PTR_W-1:0] top_q, top_nxt, eff_idx, opnd_addr, dst_addr, ext_addr;
  fps_flags_t flags_q, flags_nxt;
  logic       flag_en;

  logic                       wa_en, wb_en;
  logic [PTR_W-1:0]           wa_addr, wb_addr;
  logic [DATA_W-1:0]          wa_data, wb_data;
  logic [DEPTH-1:0]           tag_clr, tag_set;
  logic [NRD-1:0][PTR_W-1:0]  rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [NRD-1:0]             rd_empty;

  assign op      = fps_op_e'(op_i);
  assign eff_idx = (op == FPS_XCHG1) ? PTR_W'(1) : idx_i;

  fps_index #(.PTR_W(PTR_W)) i_idx_opnd (.base_i(top_q), .off_i(eff_idx),       .phys_o(opnd_addr));
  fps_index #(.PTR_W(PTR_W)) i_idx_dst  (.base_i(top_q), .off_i({PTR_W{1'b1}}), .phys_o(dst_addr));
  fps_index #(.PTR_W(PTR_W)) i_idx_ext  (.base_i(top_q), .off_i(idx_i),         .phys_o(ext_addr));

  always_comb begin
    rd_addr          = '0;
    rd_addr[RD_ST0]  = top_q;
    rd_addr[RD_OPND] = opnd_addr;
    rd_addr[RD_DST]  = dst_addr;
    rd_addr[RD_EXT]  = ext_addr;
  end

  fps_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W), .NRD(NRD)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wa_en_i    (wa_en),
    .wa_addr_i  (wa_addr),
    .wa_data_i  (wa_data),
    .wb_en_i    (wb_en),
    .wb_addr_i  (wb_addr),
    .wb_data_i  (wb_data),
    .tag_clr_i  (tag_clr),
    .tag_set_i  (tag_set),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .rd_empty_o (rd_empty)
  );

  fps_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_ctrl (
    .valid_i      (op_valid_i),
    .op_i         (op),
    .top_i        (top_q),
    .opnd_addr_i  (opnd_addr),
    .dst_addr_i   (dst_addr),
    .st0_empty_i  (rd_empty[RD_ST0]),
    .opnd_empty_i (rd_empty[RD_OPND]),
    .dst_empty_i  (rd_empty[RD_DST]),
    .st0_i        (rd_data[RD_ST0]),
    .opnd_i       (rd_data[RD_OPND]),
    .push_data_i  (push_data_i),
    .wa_en_o      (wa_en),
    .wa_addr_o    (wa_addr),
    .wa_data_o    (wa_data),
    .wb_en_o      (wb_en),
    .wb_addr_o    (wb_addr),
    .wb_data_o    (wb_data),
    .tag_clr_o    (tag_clr),
    .tag_set_o    (tag_set),
    .top_nxt_o    (top_nxt),
    .flag_en_o    (flag_en),
    .flags_o      (flags_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q   <= '0;
      flags_q <= '0;
    end else begin
      top_q <= top_nxt;
      if (flag_en) flags_q <= flags_nxt;
    end
  end

  always_comb begin
    status_o                          = '0;
    status_o[STAT_TOP_LSB +: PTR_W]   = top_q;
    status_o[STAT_C1]                 = flags_q.c1;
    status_o[STAT_SF]                 = flags_q.sf;
    status_o[STAT_IE]                 = flags_q.ie;
  end

  assign st0_o         = rd_data[RD_ST0];
  assign sti_o         = rd_data[RD_EXT];
  assign stack_fault_o = flags_q.sf;
  assign invalid_o     = flags_q.ie;
  assign c1_o          = flags_q.c1;
endmodule

// File: rtl/fps_stack_checker.sv
module fps_stack_checker
  import fps_pkg::*;
#(
  parameter int unsigned DATA_W = 80,
  parameter int unsigned PTR_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic [DATA_W-1:0] st0_o,
  input logic [DATA_W-1:0] sti_o,
  input logic [15:0]       status_o,
  input logic              stack_fault_o,
  input logic              invalid_o,
  input logic              c1_o
);
  logic [PTR_W-1:0] top_w;
  logic is_push, is_dup, is_xchg, is_pop, is_rd;
  assign top_w   = status_o[STAT_TOP_LSB +: PTR_W];
  assign is_push = op_valid_i && op_i == FPS_PUSH;
  assign is_dup  = op_valid_i && op_i == FPS_DUP;
  assign is_xchg = op_valid_i && (op_i == FPS_XCHG || op_i == FPS_XCHG1);
  assign is_pop  = op_valid_i && op_i == FPS_POP;
  assign is_rd   = op_valid_i && (op_i == FPS_STORE || op_i == FPS_STORE_POP || op_i == FPS_POP);

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_push |=> stack_fault_o || (top_w == $past(top_w) - 1'b1 && st0_o == $past(push_data_i))); // R2
  AST_DUP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dup |=> stack_fault_o || invalid_o || st0_o == $past(sti_o)); // R3
  AST_POP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pop |=> stack_fault_o || top_w == $past(top_w) + 1'b1); // R7
  AST_XCHG_C1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_xchg |=> !c1_o); // R6
  AST_OVF_C1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_push || is_dup) |=> !stack_fault_o || c1_o); // R8
  AST_UNDER_C1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |=> !c1_o); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> !(stack_fault_o || invalid_o) || (top_w == $past(top_w) && st0_o == $past(st0_o))); // R11
  AST_IDLE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(status_o)); // R12
endmodule

bind fp_stack_ctrl fps_stack_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_fps_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_valid_i    (op_valid_i),
  .op_i          (op_i),
  .push_data_i   (push_data_i),
  .st0_o         (st0_o),
  .sti_o         (sti_o),
  .status_o      (status_o),
  .stack_fault_o (stack_fault_o),
  .invalid_o     (invalid_o),
  .c1_o          (c1_o)
);

// File: tb/test_fp_stack_ctrl.sv
`timescale 1ns/1ps
module test_fp_stack_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [2:0]  idx_i = '0;
  logic [79:0] push_data_i = '0;
  logic [79:0] st0_o, sti_o;
  logic [15:0] status_o;
  logic        stack_fault_o, invalid_o, c1_o;

  fp_stack_ctrl i_fp_stack_ctrl (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [79:0] m_val [8];
  bit          m_empty [8];
  int          m_top;
  bit          m_sf, m_ie, m_c1;

  task automatic chk(string req, string what, logic [79:0] got, logic [79:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_apply(int op, int idx, logic [79:0] d);
    int t = m_top;
    int a = (t + ((op == 6) ? 1 : idx)) % 8;
    int dn = (t + 7) % 8;
    logic [79:0] tmp;
    if (op == 0) return;
    m_sf = 0; m_ie = 0; m_c1 = 0;
    case (op)
      1, 2: begin
        if (!m_empty[dn]) begin m_sf = 1; m_c1 = 1; end
        else if (op == 2 && m_empty[a]) m_ie = 1;
        else begin
          m_val[dn] = (op == 1) ? d : m_val[a];
          m_empty[dn] = 0; m_top = dn;
        end
      end
      3, 4: begin
        if (m_empty[t]) begin m_sf = 1; m_ie = 1; end
        else begin
          m_val[a] = m_val[t]; m_empty[a] = 0;
          if (op == 4) begin m_empty[t] = 1; m_top = (t + 1) % 8; end
        end
      end
      5, 6: begin
        if (m_empty[t]) begin m_sf = 1; m_ie = 1; end
        else if (m_empty[a]) m_ie = 1;
        else begin tmp = m_val[t]; m_val[t] = m_val[a]; m_val[a] = tmp; end
      end
      default: begin
        if (m_empty[t]) m_sf = 1;
        else begin m_empty[t] = 1; m_top = (t + 1) % 8; end
      end
    endcase
  endtask

  task automatic check_state(string req);
    logic [15:0] exp_st;
    exp_st = 16'(m_top) << 11 | 16'(m_c1) << 9 | 16'(m_sf) << 6 | 16'(m_ie);
    chk(req, "status", 80'(status_o), 80'(exp_st));
    chk(req, "sf/ie/c1", 80'({stack_fault_o, invalid_o, c1_o}), 80'({m_sf, m_ie, m_c1}));
    if (!m_empty[m_top]) chk(req, "st0", st0_o, m_val[m_top]);
    for (int i = 0; i < 8; i++) begin
      idx_i = 3'(i);
      #1;
      if (!m_empty[(m_top + i) % 8]) chk({req, " R13"}, "sti", sti_o, m_val[(m_top + i) % 8]);
    end
  endtask

  task automatic do_op(string req, int op, int idx, logic [79:0] d);
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = 3'(op); idx_i = 3'(idx); push_data_i = d;
    @(posedge clk_i);
    model_apply(op, idx, d);
    @(negedge clk_i);
    op_valid_i = 1'b0; op_i = '0;
    #1;
    check_state(req);
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom, $urandom, 16'($urandom)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_empty[i] = 1; end
    m_top = 0; m_sf = 0; m_ie = 0; m_c1 = 0;
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    check_state("R1");
    do_op("R1 R9 pop-empty", 7, 0, '0);
    do_op("R9 xchg-empty", 5, 1, '0);
    do_op("R9 store-empty", 3, 2, '0);
    do_op("R2 R13 push wrap", 1, 0, 80'hA1);
    do_op("R10 dup-empty-src", 2, 3, '0);
    do_op("R10 xchg-empty-sti", 5, 2, '0);
    do_op("R3 dup0", 2, 0, '0);
    do_op("R2 push", 1, 0, 80'hB2);
    do_op("R3 dup2", 2, 2, '0);
    do_op("R6 xchg1", 6, 5, '0);
    do_op("R6 xchg2", 5, 2, '0);
    do_op("R4 store", 3, 5, '0);
    do_op("R5 storepop1", 4, 1, '0);
    do_op("R5 storepop0", 4, 0, '0);
    do_op("R12 nop", 0, 0, '0);
    for (int k = 0; k < 8; k++) do_op("R2 fill", 1, 0, rnd80());
    do_op("R8 R11 overflow push", 1, 0, 80'hDEAD);
    do_op("R8 R11 overflow dup", 2, 1, '0);
    for (int k = 0; k < 9; k++) do_op("R7 R13 drain", 7, 0, '0);
    do_op("R11 underflow pop", 7, 0, '0);
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom_range(0, 7));
      do_op($sformatf("R%0d random", (op == 0) ? 12 : (op == 6 ? 6 : op + ((op > 5) ? 0 : 1))),
            op, int'($urandom_range(0, 7)), rnd80());
    end
    finish_run();
  end
endmodule